// File: doc/BRIEF.md
# Read-Only I2C Key-Status Slave

This block is a bus target that lets an I2C master read a 16-bit touch-key status vector. It oversamples the serial clock and data lines with the system clock, finds the bus start and stop conditions, and compares the first byte of each transfer against a fixed 7-bit device address. The data direction bit must request a read.

When the address matches and a read is requested, the block acknowledges. It takes a snapshot of the key vector and sends it one byte at a time, most significant bit first. The low key byte goes first, then the high key byte. The two bytes keep alternating for as long as the master acknowledges. The block only ever pulls the data line low, and reports this on a pull-low enable for an open-drain pad.

It has no write path, no internal register addressing and no clock stretching. A write request, or any other address, is not acknowledged. The block then stays off the bus until the next start or stop condition.

Top module: `key_i2c_slave`

## Requirements
- R1: While reset is asserted, and after it is released with the bus idle, `sda_pull_o` is 0 (SDA released).
- R2: A falling SDA while SCL is high (START) begins address reception. A rising SDA while SCL is high (STOP) returns the block to idle, including in the middle of an address byte.
- R3: If the address byte received MSB first equals 1010111 followed by R/W = 1 (byte value 0xAF), the block pulls SDA low during the ninth SCL clock.
- R4: An address byte with R/W = 0 (0xAE), or with any other 7-bit address, gets no acknowledge. SDA then stays released for every following clock until the next START or STOP.
- R5: The first data byte carries keys 7..0 and the second carries keys 15..8. Each byte is sent MSB first, so key 7 is the first bit on the bus and key 8 is the last bit of the second byte.
- R6: The key vector is captured when the address is acknowledged. Changes on `keys_i` after that point do not alter the bytes of the current transfer.
- R7: `sda_pull_o` changes only while the synchronised SCL is low.
- R8: After the master acknowledges a data byte (SDA low on its ninth clock), the next byte follows. The order is low byte, then high byte, repeating for as many bytes as the master acknowledges.
- R9: After a byte the master does not acknowledge (SDA high on its ninth clock), the block releases SDA. It keeps SDA released on any further clocks until a STOP or START.
- R10: A START seen in any state, including partway through an address byte or while waiting after a refused request, restarts address reception.
- R11: During the master's acknowledge clock after each data byte, SDA is released by the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| keys_i | input | 16 | Current touch-key status, bit n is key n |
| scl_i | input | 1 | Bus serial clock line, asynchronous |
| sda_i | input | 1 | Bus serial data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | 1 pulls the open-drain data line low, 0 releases it |

## Verification
The bench targets the points where a slave that miscounts clock edges or mishandles state would go wrong. A transfer of five acknowledged bytes checks the low/high alternation. A design that stops after two bytes, or fails to wrap, would send 0xFF or repeat the high byte. Changing the keys between bytes shows whether the vector is sampled at the acknowledge or live.

Write requests, foreign addresses and a not-acknowledged byte are followed by extra master clocks while any pull on SDA is watched. A slave that keeps transmitting, or that still acknowledges a write, would pull the line low there. Starts and stops inserted partway through an address byte check that a stale bit count is discarded. Without that, the next address would be misread and left unacknowledged.

// File: rtl/key_i2c_pkg.sv
package key_i2c_pkg;

    localparam int BYTE_W = 8;
    localparam int BCNT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT
    } fsm_state_e;

endpackage

// File: rtl/key_i2c_line_sync.sv
module key_i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic line_o,
    output logic line_prev_o
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[STAGES-2:0], line_i};
        s_d.prev = s_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_o      = s_q.pipe[STAGES-1];
    assign line_prev_o = s_q.prev;

endmodule

// File: rtl/key_i2c_cond_detect.sv
module key_i2c_cond_detect (
    input  logic scl_lvl_i,
    input  logic scl_prev_i,
    input  logic sda_lvl_i,
    input  logic sda_prev_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    logic scl_held_high;

    always_comb begin
        scl_held_high = scl_lvl_i & scl_prev_i;
        start_o       = scl_held_high & sda_prev_i & ~sda_lvl_i;
        stop_o        = scl_held_high & ~sda_prev_i & sda_lvl_i;
        scl_rise_o    = scl_lvl_i & ~scl_prev_i;
        scl_fall_o    = ~scl_lvl_i & scl_prev_i;
    end

endmodule

// File: rtl/key_i2c_fsm.sv
module key_i2c_fsm
    import key_i2c_pkg::*;
#(
    parameter int         KEY_W    = 16,
    parameter logic [6:0] DEV_ADDR = 7'b1010111
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [KEY_W-1:0] keys_i,
    input  logic             sda_lvl_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    output logic             sda_pull_o,
    output fsm_state_e       state_o
);

    localparam int NUM_BYTES = KEY_W / BYTE_W;
    localparam int SEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
    localparam logic [BCNT_W-1:0] BITS_DONE = BCNT_W'(BYTE_W);
    localparam logic [BCNT_W-1:0] ACK_SEEN  = BCNT_W'(BYTE_W + 1);
    localparam logic [SEL_W-1:0]  SEL_LAST  = SEL_W'(NUM_BYTES - 1);
    localparam logic [BYTE_W-1:0] RD_MATCH  = {DEV_ADDR, 1'b1};

    typedef struct packed {
        fsm_state_e        st;
        logic [BCNT_W-1:0] bcnt;
        logic [BYTE_W-1:0] sh;
        logic [KEY_W-1:0]  snap;
        logic [SEL_W-1:0]  sel;
        logic              pull;
    } regs_t;

    regs_t r_d, r_q;
    logic [BYTE_W-1:0] cur_byte;
    logic [SEL_W-1:0]  sel_next;

    always_comb begin
        cur_byte = r_q.snap[32'(r_q.sel) * BYTE_W +: BYTE_W];
        sel_next = (r_q.sel == SEL_LAST) ? '0 : r_q.sel + 1'b1;
    end

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.st   = ST_ADDR;
            r_d.bcnt = '0;
            r_d.sh   = '0;
            r_d.pull = 1'b0;
        end else if (stop_i) begin
            r_d.st   = ST_IDLE;
            r_d.pull = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        r_d.sh   = {r_q.sh[BYTE_W-2:0], sda_lvl_i};
                        r_d.bcnt = r_q.bcnt + 1'b1;
                    end else if (scl_fall_i && r_q.bcnt == BITS_DONE) begin
                        if (r_q.sh == RD_MATCH) begin
                            r_d.st   = ST_ADDR_ACK;
                            r_d.pull = 1'b1;
                            r_d.snap = keys_i;
                            r_d.sel  = '0;
                        end else begin
                            r_d.st   = ST_WAIT;
                            r_d.pull = 1'b0;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        r_d.st   = ST_TX;
                        r_d.sh   = cur_byte;
                        r_d.pull = ~cur_byte[BYTE_W-1];
                        r_d.bcnt = '0;
                        r_d.sel  = sel_next;
                    end
                end
                ST_TX: begin
                    if (scl_rise_i) begin
                        r_d.bcnt = r_q.bcnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (r_q.bcnt == BITS_DONE) begin
                            r_d.st   = ST_TX_ACK;
                            r_d.pull = 1'b0;
                        end else begin
                            r_d.sh   = {r_q.sh[BYTE_W-2:0], 1'b0};
                            r_d.pull = ~r_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise_i) begin
                        if (sda_lvl_i) begin
                            r_d.st = ST_WAIT;
                        end else begin
                            r_d.bcnt = ACK_SEEN;
                        end
                    end else if (scl_fall_i && r_q.bcnt == ACK_SEEN) begin
                        r_d.st   = ST_TX;
                        r_d.sh   = cur_byte;
                        r_d.pull = ~cur_byte[BYTE_W-1];
                        r_d.bcnt = '0;
                        r_d.sel  = sel_next;
                    end
                end
                ST_WAIT: r_d.pull = 1'b0;
                default: begin
                    r_d.st   = ST_IDLE;
                    r_d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull_o = r_q.pull;
    assign state_o    = r_q.st;

endmodule

// File: rtl/key_i2c_slave.sv
module key_i2c_slave
    import key_i2c_pkg::*;
#(
    parameter int         KEY_W       = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b1010111
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [KEY_W-1:0] keys_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o
);

    localparam int LINES = 2;
    localparam int L_SDA = 0;
    localparam int L_SCL = 1;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] line_lvl;
    logic [LINES-1:0] line_prev;
    logic             scl_lvl;
    logic             start_det;
    logic             stop_det;
    logic             scl_rise;
    logic             scl_fall;
    fsm_state_e       fsm_state;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        key_i2c_line_sync #(
            .STAGES(SYNC_STAGES)
        ) u_sync (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .line_i     (raw_lines[g]),
            .line_o     (line_lvl[g]),
            .line_prev_o(line_prev[g])
        );
    end

    assign scl_lvl = line_lvl[L_SCL];

    key_i2c_cond_detect u_cond (
        .scl_lvl_i (scl_lvl),
        .scl_prev_i(line_prev[L_SCL]),
        .sda_lvl_i (line_lvl[L_SDA]),
        .sda_prev_i(line_prev[L_SDA]),
        .start_o   (start_det),
        .stop_o    (stop_det),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall)
    );

    key_i2c_fsm #(
        .KEY_W   (KEY_W),
        .DEV_ADDR(DEV_ADDR)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .keys_i    (keys_i),
        .sda_lvl_i (line_lvl[L_SDA]),
        .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall),
        .start_i   (start_det),
        .stop_i    (stop_det),
        .sda_pull_o(sda_pull_o),
        .state_o   (fsm_state)
    );

endmodule

// File: rtl/key_i2c_slave_chk.sv
module key_i2c_slave_chk
    import key_i2c_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       sda_pull_o,
    input logic       scl_lvl,
    input logic       start_det,
    input logic       stop_det,
    input fsm_state_e state
);

    p_reset_release_r1: assert property (@(posedge clk_i)
        !rst_ni |=> !sda_pull_o);

    p_stop_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_det && !start_det) |=> state == ST_IDLE);

    p_ack_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state == ST_ADDR_ACK |-> sda_pull_o);

    p_pull_on_low_scl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_pull_o) |-> !scl_lvl);

    p_wait_released_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state == ST_WAIT |-> !sda_pull_o);

    p_start_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_det |=> state == ST_ADDR);

    p_ack_slot_free_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state == ST_TX_ACK |-> !sda_pull_o);

endmodule

bind key_i2c_slave key_i2c_slave_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_pull_o(sda_pull_o),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .state     (fsm_state)
);

// File: tb/tb_key_i2c_slave.sv
`timescale 1ns/1ps
module tb_key_i2c_slave;

    localparam int Q = 10;
    localparam logic [6:0] ADDR = 7'b1010111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] keys = '0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_bus;

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_pull;

    key_i2c_slave dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .keys_i    (keys),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_pull_o(sda_pull)
    );

    int vectors = 0;
    int miscompares = 0;
    bit watch = 0;
    int stray = 0;
    bit done = 0;
    logic last_bit;
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string tag_q[$];

    always @(negedge clk) if (watch && sda_pull) stray++;

    // scoreboard monitor
    always @(negedge clk) begin
        if (got_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] g, e;
            string t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (g !== e) begin
                miscompares++;
                $display("FAIL %s data byte: actual %02h expected %02h", t, g, e);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; qw();
        scl_m = 1'b1; qw();
        last_bit = sda_bus; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask

    task automatic get_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1);
            v[i] = last_bit;
        end
    endtask

    task automatic read_txn(input logic [6:0] a, input int n,
                            input bit chg, input logic [15:0] nk, input string tag);
        logic [15:0] snap;
        logic [7:0] b;
        snap = keys;
        bus_start();
        put_byte({a, 1'b1});
        put_bit(1'b1);
        chk(last_bit == 1'b0, {tag, " R3 address ack"}, int'(last_bit), 0);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back((i % 2 == 0) ? snap[7:0] : snap[15:8]);
            tag_q.push_back(tag);
            get_byte(b);
            got_q.push_back(b);
            if (chg && i == 0) keys = nk;
            put_bit((i == n - 1) ? 1'b1 : 1'b0);
            if (i == n - 1)
                chk(last_bit == 1'b1, "R11 released in ack slot", int'(last_bit), 1);
        end
        bus_stop();
    endtask

    initial begin
        logic [7:0] b;
        repeat (4) @(negedge clk);
        chk(sda_pull == 1'b0, "R1 pull during reset", int'(sda_pull), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(sda_pull == 1'b0, "R1 pull after reset", int'(sda_pull), 0);

        // R2 R3 R5: two bytes, low then high, MSB first
        keys = 16'hA53C;
        read_txn(ADDR, 2, 1'b0, '0, "R5");

        // R8: streaming alternates low/high
        keys = 16'h8001;
        read_txn(ADDR, 5, 1'b0, '0, "R8");

        // R6: snapshot held across keys change
        keys = 16'h1234;
        read_txn(ADDR, 2, 1'b1, 16'hFFFF, "R6");

        // R4: write request refused, bus left alone
        keys = 16'h0000;
        bus_start();
        put_byte({ADDR, 1'b0});
        watch = 1; stray = 0;
        put_bit(1'b1);
        chk(last_bit == 1'b1, "R4 write not acked", int'(last_bit), 1);
        get_byte(b);
        watch = 0;
        chk(stray == 0, "R4 no drive after write", stray, 0);
        chk(b == 8'hFF, "R4 bus idle after write", int'(b), 255);
        bus_stop();

        // R4: foreign address
        bus_start();
        put_byte({7'h2B, 1'b1});
        watch = 1; stray = 0;
        put_bit(1'b1);
        chk(last_bit == 1'b1, "R4 foreign address not acked", int'(last_bit), 1);
        get_byte(b);
        watch = 0;
        chk(stray == 0, "R4 no drive after foreign address", stray, 0);
        bus_stop();

        // R9: nack then extra clocks
        keys = 16'h0000;
        bus_start();
        put_byte({ADDR, 1'b1});
        put_bit(1'b1);
        chk(last_bit == 1'b0, "R9 address ack", int'(last_bit), 0);
        get_byte(b);
        chk(b == 8'h00, "R9 first byte", int'(b), 0);
        put_bit(1'b1);
        watch = 1; stray = 0;
        get_byte(b);
        put_bit(1'b1);
        watch = 0;
        chk(stray == 0, "R9 no drive after nack", stray, 0);
        chk(b == 8'hFF, "R9 released after nack", int'(b), 255);
        bus_stop();

        // R10: start partway through address
        keys = 16'h5AC3;
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        read_txn(ADDR, 2, 1'b0, '0, "R10 mid-address");

        // R10: start while waiting after a refused write
        keys = 16'h0F69;
        bus_start();
        put_byte({ADDR, 1'b0});
        put_bit(1'b1);
        chk(last_bit == 1'b1, "R10 write refused", int'(last_bit), 1);
        read_txn(ADDR, 2, 1'b0, '0, "R10 after refuse");

        // R2: stop mid-address returns idle
        keys = 16'hC07E;
        bus_start();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
        scl_m = 1'b0; sda_m = 1'b0; qw();
        bus_stop();
        chk(sda_pull == 1'b0, "R2 idle after stop", int'(sda_pull), 0);
        read_txn(ADDR, 2, 1'b0, '0, "R2 after stop");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule